// File: doc/BRIEF.md
# Synchronous Pipelined Dual-Port RAM

This block is a true dual-port memory of 36-bit words, each word split into four 9-bit bytes. It has two independent ports, left (A) and right (B), on one shared clock. Every address, data and control pin of a port is captured in a register on the rising clock edge. The access then takes place in the next cycle. Read data passes through an output pipeline register, so a read presented before edge k is visible after edge k+2. Only the output enable bypasses the registers: it gates the read-data drivers combinationally.

Each port holds a burst address counter. The counter can be cleared, loaded from the address pins, advanced by one, or held, so the port can run stallable bursts without the address being supplied every cycle. Two chip enables select each port, and the port is selected only when `ce0` is low and `ce1` is high. A deselected cycle performs no access and leaves the counter untouched. The outputs come back two edges after the port is selected again. Wiring an upper address bit to `ce1` of one instance and to `ce0` of another stacks two instances in depth with no extra logic. The depth is a power-of-two parameter.

Top module: `dpram_top`

## Requirements
- R1: For a selected read captured at rising edge k, the word stored at the access address appears on `rdata_o` after edge k+2 and before edge k+3.
- R2: `rdata_oe_o` is high only while `oe_i` is high and pipelined read data is present. Its response to `oe_i` is combinational, in the same cycle. While `rdata_oe_o` is low, `rdata_o` is all zeros.
- R3: A captured `cntrst_i` high makes that access use address 0 and leaves the counter at 0. This holds even when `ads_i` or `cnten_i` is also high.
- R4: When `cntrst_i` is low, a captured `ads_i` high makes the access use `addr_i` and loads it into the counter. This takes priority over `cnten_i`.
- R5: When `cntrst_i` and `ads_i` are low, `cnten_i` high accesses the counter value plus one, wrapping from DEPTH-1 to 0. With `cnten_i` low, the access repeats the counter value.
- R6: A port is deselected in any cycle where `ce0_i` is captured high or `ce1_i` is captured low. In that cycle it does not write, its counter ignores `cntrst_i`, `ads_i` and `cnten_i`, and it drives no read data for that cycle.
- R7: After reset, and after any deselect, the outputs are undriven until a selected read returns through the pipeline two edges after its capture.
- R8: A write (`wr_i` high) stores byte i, bits 9i+8 down to 9i, only where `be_i[i]` is high. The other bytes of the word keep their contents.
- R9: When both ports write the same address in the same cycle, each byte enabled by port A takes A's data. Bytes enabled only by port B take B's data.
- R10: A read of an address that the other port writes in the same cycle returns the data held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both ports |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_ce0_i | input | 1 | Port A chip enable, active low |
| a_ce1_i | input | 1 | Port A chip enable, active high |
| a_wr_i | input | 1 | Port A: 1 = write, 0 = read |
| a_be_i | input | 4 | Port A byte write enables, bit i selects byte i |
| a_ads_i | input | 1 | Port A: load the address pins into the counter |
| a_cnten_i | input | 1 | Port A: advance the counter |
| a_cntrst_i | input | 1 | Port A: clear the counter |
| a_addr_i | input | AW | Port A external address |
| a_wdata_i | input | 36 | Port A write data |
| a_oe_i | input | 1 | Port A output enable, not registered |
| a_rdata_o | output | 36 | Port A read data, zero when undriven |
| a_rdata_oe_o | output | 1 | Port A read-data driver enable |
| b_ce0_i | input | 1 | Port B chip enable, active low |
| b_ce1_i | input | 1 | Port B chip enable, active high |
| b_wr_i | input | 1 | Port B: 1 = write, 0 = read |
| b_be_i | input | 4 | Port B byte write enables |
| b_ads_i | input | 1 | Port B: load the address pins into the counter |
| b_cnten_i | input | 1 | Port B: advance the counter |
| b_cntrst_i | input | 1 | Port B: clear the counter |
| b_addr_i | input | AW | Port B external address |
| b_wdata_i | input | 36 | Port B write data |
| b_oe_i | input | 1 | Port B output enable, not registered |
| b_rdata_o | output | 36 | Port B read data, zero when undriven |
| b_rdata_oe_o | output | 1 | Port B read-data driver enable |

## Verification
Some rules are checked on every cycle. In the counters these are the clear, load, increment-with-wrap and hold rules. In the port pipeline, a deselected cycle must leave the driver enable low two edges later. Three behaviours can only be shown by the bench's scenarios, which compare both outputs every cycle against a reference memory and counter model:

- the two-edge read latency;
- the byte-masked and colliding writes, with port A winning;
- old data on a read-write clash, and combinational gating by the output enable.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int BYTES  = 4;
  localparam int BYTE_W = 9;
  localparam int WORD_W = BYTES * BYTE_W;

  typedef struct packed {
    logic             sel;
    logic             wr;
    logic [BYTES-1:0] be;
    logic             ads;
    logic             cnten;
    logic             cntrst;
  } port_ctl_t;
endpackage

// File: rtl/dp_burst_counter.sv
module dp_burst_counter #(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic          inc_i,
  input  logic [AW-1:0] load_addr_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] cnt_q, cnt_d;

  // priority: clear, load, increment, hold
  always_comb begin
    if (clr_i)       cnt_d = '0;
    else if (load_i) cnt_d = load_addr_i;
    else if (inc_i)  cnt_d = cnt_q + AW'(1);
    else             cnt_d = cnt_q;
  end

  assign addr_o = cnt_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_d;
  end

  assert_cnt_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && clr_i) |=> (cnt_q == '0));

  assert_cnt_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && load_i) |=> (cnt_q == $past(load_addr_i)));

  assert_cnt_inc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && !load_i && inc_i) |=> (cnt_q == AW'($past(cnt_q) + 1'b1)));

  assert_cnt_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dp_mem_array.sv
module dp_mem_array import dpram_pkg::*; #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     a_addr_i,
  input  logic              a_we_i,
  input  logic              a_re_i,
  input  logic [BYTES-1:0]  a_be_i,
  input  logic [WORD_W-1:0] a_wdata_i,
  output logic [WORD_W-1:0] a_rdata_o,
  input  logic [AW-1:0]     b_addr_i,
  input  logic              b_we_i,
  input  logic              b_re_i,
  input  logic [BYTES-1:0]  b_be_i,
  input  logic [WORD_W-1:0] b_wdata_i,
  output logic [WORD_W-1:0] b_rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  // reads sample the array before this edge's writes land: old data on a clash
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_rdata_o <= '0;
      b_rdata_o <= '0;
    end else begin
      if (a_re_i) a_rdata_o <= mem_q[a_addr_i];
      if (b_re_i) b_rdata_o <= mem_q[b_addr_i];
    end
  end

  // port B first, port A second: A overrides on shared bytes
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < BYTES; i++) begin
      if (b_we_i && b_be_i[i]) mem_q[b_addr_i][i*BYTE_W +: BYTE_W] <= b_wdata_i[i*BYTE_W +: BYTE_W];
      if (a_we_i && a_be_i[i]) mem_q[a_addr_i][i*BYTE_W +: BYTE_W] <= a_wdata_i[i*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/dp_port_ctrl.sv
module dp_port_ctrl import dpram_pkg::*; #(
  parameter int AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce0_i,
  input  logic              ce1_i,
  input  logic              wr_i,
  input  logic [BYTES-1:0]  be_i,
  input  logic              ads_i,
  input  logic              cnten_i,
  input  logic              cntrst_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              oe_i,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [BYTES-1:0]  mem_be_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rdata_oe_o
);
  port_ctl_t         ctl_q;
  logic [AW-1:0]     addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic              rd_vld_q, drv_q;
  logic [WORD_W-1:0] dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      ctl_q.sel    <= ~ce0_i & ce1_i;
      ctl_q.wr     <= wr_i;
      ctl_q.be     <= be_i;
      ctl_q.ads    <= ads_i;
      ctl_q.cnten  <= cnten_i;
      ctl_q.cntrst <= cntrst_i;
      addr_q       <= addr_i;
      wdata_q      <= wdata_i;
    end
  end

  dp_burst_counter #(.AW(AW)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (ctl_q.sel),
    .clr_i       (ctl_q.cntrst),
    .load_i      (ctl_q.ads),
    .inc_i       (ctl_q.cnten),
    .load_addr_i (addr_q),
    .addr_o      (mem_addr_o)
  );

  assign mem_we_o    = ctl_q.sel & ctl_q.wr;
  assign mem_re_o    = ctl_q.sel & ~ctl_q.wr;
  assign mem_be_o    = ctl_q.be;
  assign mem_wdata_o = wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q <= 1'b0;
      drv_q    <= 1'b0;
      dout_q   <= '0;
    end else begin
      rd_vld_q <= mem_re_o;
      drv_q    <= rd_vld_q;
      if (rd_vld_q) dout_q <= mem_rdata_i;
    end
  end

  // output enable is not registered
  assign rdata_oe_o = oe_i & drv_q;
  assign rdata_o    = rdata_oe_o ? dout_q : '0;

  assert_desel_dark_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_q.sel) |-> ##2 (!drv_q));

  assert_write_dark_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.sel && ctl_q.wr) |-> ##2 (!drv_q));
endmodule

// File: rtl/dpram_top.sv
module dpram_top import dpram_pkg::*; #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_ce0_i,
  input  logic              a_ce1_i,
  input  logic              a_wr_i,
  input  logic [BYTES-1:0]  a_be_i,
  input  logic              a_ads_i,
  input  logic              a_cnten_i,
  input  logic              a_cntrst_i,
  input  logic [AW-1:0]     a_addr_i,
  input  logic [WORD_W-1:0] a_wdata_i,
  input  logic              a_oe_i,
  output logic [WORD_W-1:0] a_rdata_o,
  output logic              a_rdata_oe_o,
  input  logic              b_ce0_i,
  input  logic              b_ce1_i,
  input  logic              b_wr_i,
  input  logic [BYTES-1:0]  b_be_i,
  input  logic              b_ads_i,
  input  logic              b_cnten_i,
  input  logic              b_cntrst_i,
  input  logic [AW-1:0]     b_addr_i,
  input  logic [WORD_W-1:0] b_wdata_i,
  input  logic              b_oe_i,
  output logic [WORD_W-1:0] b_rdata_o,
  output logic              b_rdata_oe_o
);
  logic [AW-1:0]     a_maddr, b_maddr;
  logic              a_mwe, a_mre, b_mwe, b_mre;
  logic [BYTES-1:0]  a_mbe, b_mbe;
  logic [WORD_W-1:0] a_mwd, b_mwd, a_mrd, b_mrd;

  dp_port_ctrl #(.AW(AW)) u_port_a (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ce0_i(a_ce0_i), .ce1_i(a_ce1_i), .wr_i(a_wr_i), .be_i(a_be_i),
    .ads_i(a_ads_i), .cnten_i(a_cnten_i), .cntrst_i(a_cntrst_i),
    .addr_i(a_addr_i), .wdata_i(a_wdata_i), .oe_i(a_oe_i),
    .mem_addr_o(a_maddr), .mem_we_o(a_mwe), .mem_re_o(a_mre),
    .mem_be_o(a_mbe), .mem_wdata_o(a_mwd), .mem_rdata_i(a_mrd),
    .rdata_o(a_rdata_o), .rdata_oe_o(a_rdata_oe_o)
  );

  dp_port_ctrl #(.AW(AW)) u_port_b (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ce0_i(b_ce0_i), .ce1_i(b_ce1_i), .wr_i(b_wr_i), .be_i(b_be_i),
    .ads_i(b_ads_i), .cnten_i(b_cnten_i), .cntrst_i(b_cntrst_i),
    .addr_i(b_addr_i), .wdata_i(b_wdata_i), .oe_i(b_oe_i),
    .mem_addr_o(b_maddr), .mem_we_o(b_mwe), .mem_re_o(b_mre),
    .mem_be_o(b_mbe), .mem_wdata_o(b_mwd), .mem_rdata_i(b_mrd),
    .rdata_o(b_rdata_o), .rdata_oe_o(b_rdata_oe_o)
  );

  dp_mem_array #(.DEPTH(DEPTH)) u_mem (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .a_addr_i(a_maddr), .a_we_i(a_mwe), .a_re_i(a_mre), .a_be_i(a_mbe),
    .a_wdata_i(a_mwd), .a_rdata_o(a_mrd),
    .b_addr_i(b_maddr), .b_we_i(b_mwe), .b_re_i(b_mre), .b_be_i(b_mbe),
    .b_wdata_i(b_mwd), .b_rdata_o(b_mrd)
  );
endmodule

// File: tb/tb_dpram_top.sv
module tb_dpram_top;
  localparam int DEPTH = 64;
  localparam int AW = 6;

  typedef struct packed {
    logic ce0; logic ce1; logic wr; logic [3:0] be;
    logic ads; logic cnten; logic rst; logic [AW-1:0] addr; logic [35:0] d;
  } cmd_t;

  typedef struct packed { int due; logic drv; logic [35:0] data; int tag; } exp_t;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic a_ce0, a_ce1, a_wr, a_ads, a_cnten, a_cntrst, a_oe;
  logic b_ce0, b_ce1, b_wr, b_ads, b_cnten, b_cntrst, b_oe;
  logic [3:0] a_be, b_be;
  logic [AW-1:0] a_addr, b_addr;
  logic [35:0] a_wd, b_wd, a_rd, b_rd;
  logic a_roe, b_roe;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  exp_t qa[$], qb[$];
  logic [35:0] mdl [DEPTH];
  logic [AW-1:0] cnt_a = '0, cnt_b = '0;

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  dpram_top #(.DEPTH(DEPTH)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .a_ce0_i(a_ce0), .a_ce1_i(a_ce1), .a_wr_i(a_wr), .a_be_i(a_be),
    .a_ads_i(a_ads), .a_cnten_i(a_cnten), .a_cntrst_i(a_cntrst),
    .a_addr_i(a_addr), .a_wdata_i(a_wd), .a_oe_i(a_oe),
    .a_rdata_o(a_rd), .a_rdata_oe_o(a_roe),
    .b_ce0_i(b_ce0), .b_ce1_i(b_ce1), .b_wr_i(b_wr), .b_be_i(b_be),
    .b_ads_i(b_ads), .b_cnten_i(b_cnten), .b_cntrst_i(b_cntrst),
    .b_addr_i(b_addr), .b_wdata_i(b_wd), .b_oe_i(b_oe),
    .b_rdata_o(b_rd), .b_rdata_oe_o(b_roe)
  );

  function automatic cmd_t mk(bit sel, bit wr, logic [3:0] be, bit ads, bit cnten,
                              bit rst, logic [AW-1:0] addr, logic [35:0] d);
    cmd_t c;
    c.ce0 = !sel; c.ce1 = sel; c.wr = wr; c.be = be; c.ads = ads;
    c.cnten = cnten; c.rst = rst; c.addr = addr; c.d = d;
    return c;
  endfunction

  function automatic logic [AW-1:0] next_addr(cmd_t c, logic [AW-1:0] cnt);
    if (c.rst) return '0;
    if (c.ads) return c.addr;
    if (c.cnten) return cnt + 1'b1;
    return cnt;
  endfunction

  function automatic logic [35:0] merge(logic [35:0] old, logic [35:0] d, logic [3:0] be);
    logic [35:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*9 +: 9] = d[i*9 +: 9];
    return r;
  endfunction

  cmd_t idle;

  // driver: apply one cycle on both ports and push the expected output
  task automatic step(cmd_t a, cmd_t b, int tag);
    bit sa, sb;
    logic [AW-1:0] ea, eb;
    logic [35:0] ra, rb;
    exp_t ia, ib;
    @(negedge clk_i);
    {a_ce0, a_ce1, a_wr, a_be, a_ads, a_cnten, a_cntrst, a_addr, a_wd} = a;
    {b_ce0, b_ce1, b_wr, b_be, b_ads, b_cnten, b_cntrst, b_addr, b_wd} = b;
    sa = !a.ce0 && a.ce1;
    sb = !b.ce0 && b.ce1;
    ea = cnt_a; eb = cnt_b;
    if (sa) begin ea = next_addr(a, cnt_a); cnt_a = ea; end
    if (sb) begin eb = next_addr(b, cnt_b); cnt_b = eb; end
    ra = mdl[ea]; rb = mdl[eb];
    if (sb && b.wr) mdl[eb] = merge(mdl[eb], b.d, b.be);
    if (sa && a.wr) mdl[ea] = merge(mdl[ea], a.d, a.be);
    ia.due = cyc + 3; ia.drv = sa && !a.wr; ia.data = ra; ia.tag = tag;
    ib.due = cyc + 3; ib.drv = sb && !b.wr; ib.data = rb; ib.tag = tag;
    qa.push_back(ia);
    qb.push_back(ib);
  endtask

  task automatic check_port(string p, exp_t it, logic oe, logic roe, logic [35:0] rd);
    logic eoe;
    logic [35:0] ed;
    eoe = it.drv & oe;
    ed  = eoe ? it.data : 36'h0;
    checks++;
    if (roe !== eoe || rd !== ed) begin
      errors++;
      $display("FAIL R%0d port %s cyc %0d: oe=%b data=%h expected oe=%b data=%h",
               it.tag, p, cyc, roe, rd, eoe, ed);
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    exp_t it;
    #2;
    if (qa.size() > 0 && qa[0].due == cyc) begin it = qa.pop_front(); check_port("A", it, a_oe, a_roe, a_rd); end
    if (qb.size() > 0 && qb[0].due == cyc) begin it = qb.pop_front(); check_port("B", it, b_oe, b_roe, b_rd); end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cmd_t c;
    idle = mk(0, 0, 4'h0, 0, 0, 0, '0, '0);
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    {a_ce0, a_ce1, a_wr, a_be, a_ads, a_cnten, a_cntrst, a_addr, a_wd} = idle;
    {b_ce0, b_ce1, b_wr, b_be, b_ads, b_cnten, b_cntrst, b_addr, b_wd} = idle;
    a_oe = 1'b1; b_oe = 1'b1;
    // zero the array through the ports so every location is known
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #2;
    checks++;  // R7: outputs undriven out of reset
    if (a_roe !== 1'b0 || b_roe !== 1'b0 || a_rd !== '0 || b_rd !== '0) begin
      errors++;
      $display("FAIL R7 reset: oe=%b%b expected 00", a_roe, b_roe);
    end
    for (int i = 0; i < DEPTH; i += 2)
      step(mk(1, 1, 4'hf, 1, 0, 0, AW'(i), 36'h0), mk(1, 1, 4'hf, 1, 0, 0, AW'(i + 1), 36'h0), 7);

    // R1: basic write then read on both ports
    step(mk(1, 1, 4'hf, 1, 0, 0, 6'd5, 36'h1_2345_6789), mk(1, 1, 4'hf, 1, 0, 0, 6'd6, 36'h9_8765_4321), 1);
    step(mk(1, 0, 4'h0, 1, 0, 0, 6'd6, '0), mk(1, 0, 4'h0, 1, 0, 0, 6'd5, '0), 1);
    step(mk(1, 0, 4'h0, 1, 0, 0, 6'd5, '0), idle, 1);

    // R5: burst write across the top with wrap, then stalled burst read
    step(mk(1, 1, 4'hf, 1, 0, 0, 6'd60, 36'hA_0000_0060), idle, 5);
    for (int i = 1; i < 6; i++) step(mk(1, 1, 4'hf, 0, 1, 0, '0, 36'hA_0000_0060 + 36'(i)), idle, 5);
    step(idle, mk(1, 0, 4'h0, 1, 0, 0, 6'd60, '0), 5);
    step(idle, mk(1, 0, 4'h0, 0, 1, 0, '0, '0), 5);
    step(idle, mk(1, 0, 4'h0, 0, 0, 0, '0, '0), 5);  // stall
    step(idle, mk(1, 0, 4'h0, 0, 0, 0, '0, '0), 5);
    for (int i = 0; i < 4; i++) step(idle, mk(1, 0, 4'h0, 0, 1, 0, '0, '0), 5);

    // R3: counter reset beats load and increment
    step(mk(1, 0, 4'h0, 1, 1, 1, 6'd9, '0), idle, 3);
    step(mk(1, 0, 4'h0, 0, 1, 0, '0, '0), idle, 3);
    // R4: load beats increment
    step(mk(1, 0, 4'h0, 1, 1, 0, 6'd61, '0), idle, 4);
    step(mk(1, 0, 4'h0, 0, 1, 0, '0, '0), idle, 4);

    // R8: byte-masked write
    step(mk(1, 1, 4'hf, 1, 0, 0, 6'd20, 36'h0), idle, 8);
    step(mk(1, 1, 4'b0101, 1, 0, 0, 6'd20, 36'hF_FFFF_FFFF), idle, 8);
    step(mk(1, 0, 4'h0, 1, 0, 0, 6'd20, '0), idle, 8);
    step(mk(1, 1, 4'b1000, 1, 0, 0, 6'd20, 36'h5_5555_5555), idle, 8);
    step(idle, mk(1, 0, 4'h0, 1, 0, 0, 6'd20, '0), 8);

    // R9: same-address write collision, A wins on its bytes
    step(mk(1, 1, 4'b0011, 1, 0, 0, 6'd30, 36'hA_AAAA_AAAA), mk(1, 1, 4'hf, 1, 0, 0, 6'd30, 36'hB_BBBB_BBBB), 9);
    step(mk(1, 1, 4'hf, 1, 0, 0, 6'd31, 36'hC_CCCC_CCCC), mk(1, 1, 4'hf, 1, 0, 0, 6'd31, 36'hD_DDDD_DDDD), 9);
    step(mk(1, 0, 4'h0, 1, 0, 0, 6'd30, '0), mk(1, 0, 4'h0, 1, 0, 0, 6'd31, '0), 9);

    // R10: read during other port's write returns old data
    step(mk(1, 1, 4'hf, 1, 0, 0, 6'd40, 36'h0_0000_1111), idle, 10);
    step(mk(1, 1, 4'hf, 1, 0, 0, 6'd40, 36'h0_0000_2222), mk(1, 0, 4'h0, 1, 0, 0, 6'd40, '0), 10);
    step(mk(1, 0, 4'h0, 1, 0, 0, 6'd41, '0), mk(1, 1, 4'hf, 1, 0, 0, 6'd41, 36'h3_3333_3333), 10);
    step(idle, mk(1, 0, 4'h0, 1, 0, 0, 6'd40, '0), 10);

    // R6: deselected cycles ignore write and counter controls
    step(mk(1, 0, 4'h0, 1, 0, 0, 6'd10, '0), idle, 6);
    step(mk(0, 1, 4'hf, 1, 0, 0, 6'd5, 36'hE_EEEE_EEEE), idle, 6);  // ce0 high
    c = mk(1, 1, 4'hf, 0, 1, 1, 6'd5, 36'hE_EEEE_EEEE);
    c.ce1 = 1'b0;                                                 // ce1 low
    step(c, idle, 6);
    c = mk(1, 0, 4'h0, 0, 1, 0, '0, '0);
    c.ce0 = 1'b1; c.ce1 = 1'b0;                                   // deselected read
    step(c, idle, 6);
    // R7: first selected read after deselect, counter still at 10
    step(mk(1, 0, 4'h0, 0, 1, 0, '0, '0), idle, 7);
    step(mk(1, 0, 4'h0, 1, 0, 0, 6'd5, '0), idle, 6);
    step(mk(1, 0, 4'h0, 0, 0, 0, '0, '0), mk(1, 0, 4'h0, 1, 0, 0, 6'd5, '0), 7);

    // R2: output enable gates drivers in the same cycle
    step(mk(1, 0, 4'h0, 1, 0, 0, 6'd5, '0), mk(1, 0, 4'h0, 1, 0, 0, 6'd6, '0), 2);
    step(mk(1, 0, 4'h0, 1, 0, 0, 6'd6, '0), mk(1, 0, 4'h0, 1, 0, 0, 6'd5, '0), 2);
    step(mk(1, 0, 4'h0, 1, 0, 0, 6'd5, '0), idle, 2);
    a_oe = 1'b0;
    step(mk(1, 0, 4'h0, 1, 0, 0, 6'd6, '0), idle, 2);
    b_oe = 1'b0;
    step(idle, idle, 2);
    a_oe = 1'b1; b_oe = 1'b1;
    step(idle, idle, 2);

    repeat (5) step(idle, idle, 7);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule